// File: doc/BRIEF.md
# Tidemark QoS Acceptance Regulator

This block sits at the target side of a shared memory port and decides which incoming requests are admitted. It keeps a count of the requests from best-effort masters that have been accepted and not yet completed. One master is treated as high priority: a request is identified as coming from it when the request's master ID equals a configured priority ID. The priority master is never counted and never held back.

Once the best-effort count reaches the configured tidemark, the regulator stops accepting requests whose ID differs from the priority ID. Requests from the priority master are still accepted. Best-effort requests are admitted again as soon as a best-effort completion brings the count back below the tidemark. A tidemark of zero turns the regulation off.

Both configuration values are captured in registers, so a change takes effect one cycle after it is applied. The ready output depends combinationally on the registered configuration, the count and the request ID presented in the current cycle. Arbitration between requesters and the memory itself lie outside this block.

Top module: `qos_tidemark_regulator`

## Requirements
- R1: After reset the best-effort count is zero, so a non-priority request is ready while the tidemark is nonzero.
- R2: A request whose ID equals the registered priority ID is always ready, and its acceptance does not change the best-effort count.
- R3: With a nonzero registered tidemark, a request whose ID differs from the priority ID is not ready while the count is greater than or equal to the tidemark.
- R4: With a nonzero registered tidemark, a non-priority request is ready while the count is below the tidemark, including in the cycle after a completion lowers the count.
- R5: The count rises by one for each accepted non-priority request (valid and ready both high). It falls by one for each completion with the best-effort flag high. A completion with the flag low leaves the count unchanged.
- R6: An accepted non-priority request and a best-effort completion in the same cycle leave the count unchanged.
- R7: A registered tidemark of zero makes every request ready, whatever its ID. The count keeps tracking requests and completions in the meantime.
- R8: A new tidemark or priority ID applied to the configuration inputs governs ready from the next cycle. If the count is above a newly lowered tidemark, non-priority requests stay blocked until the count falls below that tidemark.
- R9: A best-effort completion while the count is zero is ignored. The count saturates at its maximum (2^CNT_W - 1) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is presented |
| req_id | input | ID_W | Master ID of the presented request |
| req_ready | output | 1 | Request may be accepted this cycle |
| cmp_valid | input | 1 | A completion occurs this cycle |
| cmp_best_effort | input | 1 | The completing request was a best-effort one |
| cfg_tidemark | input | CNT_W | Limit on outstanding best-effort requests; 0 disables regulation |
| cfg_prio_id | input | ID_W | Master ID treated as high priority |

## Verification
The bench checks the boundary where the count equals the tidemark. A design with an off-by-one comparison would admit a fifth best-effort request, or would block at three. It lowers the tidemark below the current count and expects blocking to persist through one completion. A design that compared for equality only would reopen too early. Other corner cases are a request and a completion in the same cycle (a counter that lets one event win drifts), a completion at zero and a long run with the tidemark at zero (a wrapping or underflowing counter then releases or blocks at the wrong point), and priority IDs under full load (a design that counted them would block best-effort traffic early).

// File: rtl/qos_reg_pkg.sv
package qos_reg_pkg;
  // Effective action applied to the best-effort counter in one cycle.
  typedef enum logic [1:0] {
    CNT_HOLD = 2'd0,
    CNT_UP   = 2'd1,
    CNT_DOWN = 2'd2
  } cnt_op_e;
endpackage

// File: rtl/qtr_cfg_regs.sv
module qtr_cfg_regs #(
  parameter int ID_W  = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tidemark_in,
  input  logic [ID_W-1:0]  prio_id_in,
  output logic [CNT_W-1:0] tidemark_q,
  output logic [ID_W-1:0]  prio_id_q
);
  logic [CNT_W-1:0] tidemark_d;
  logic [ID_W-1:0]  prio_id_d;
  logic             cfg_en;

  always_comb begin
    cfg_en     = 1'b1;
    tidemark_d = tidemark_in;
    prio_id_d  = prio_id_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tidemark_q <= '0;
      prio_id_q  <= '0;
    end else if (cfg_en) begin
      tidemark_q <= tidemark_d;
      prio_id_q  <= prio_id_d;
    end
  end
endmodule

// File: rtl/qtr_id_match.sv
module qtr_id_match #(
  parameter int ID_W = 4
) (
  input  logic [ID_W-1:0] id,
  input  logic [ID_W-1:0] prio_id,
  output logic            hit
);
  always_comb hit = (id == prio_id);
endmodule

// File: rtl/qtr_be_counter.sv
module qtr_be_counter
  import qos_reg_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  cnt_op_e          op;
  logic             inc_eff;
  logic             dec_eff;
  logic [CNT_W-1:0] count_d;
  logic             count_en;

  always_comb begin
    inc_eff = inc && (count != CNT_MAX);
    dec_eff = dec && (count != '0);
    unique case ({inc_eff, dec_eff})
      2'b10:   op = CNT_UP;
      2'b01:   op = CNT_DOWN;
      default: op = CNT_HOLD;
    endcase
    count_en = (op != CNT_HOLD);
    unique case (op)
      CNT_UP:   count_d = count + CNT_W'(1);
      CNT_DOWN: count_d = count - CNT_W'(1);
      default:  count_d = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count <= '0;
    else if (count_en) count <= count_d;
  end
endmodule

// File: rtl/qtr_admit_gate.sv
module qtr_admit_gate #(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] tidemark,
  input  logic             prio_hit,
  output logic             ready
);
  logic reg_off;
  logic below;

  always_comb begin
    reg_off = (tidemark == '0);
    below   = (count < tidemark);
    ready   = prio_hit || reg_off || below;
  end
endmodule

// File: rtl/qos_tidemark_regulator.sv
module qos_tidemark_regulator #(
  parameter int ID_W  = 4,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ID_W-1:0]  req_id,
  output logic             req_ready,
  input  logic             cmp_valid,
  input  logic             cmp_best_effort,
  input  logic [CNT_W-1:0] cfg_tidemark,
  input  logic [ID_W-1:0]  cfg_prio_id
);
  logic [CNT_W-1:0] tm_q;
  logic [ID_W-1:0]  pid_q;
  logic             id_hit;
  logic [CNT_W-1:0] be_count;
  logic             be_inc;
  logic             be_dec;

  qtr_cfg_regs #(.ID_W(ID_W), .CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .tidemark_in(cfg_tidemark), .prio_id_in(cfg_prio_id),
    .tidemark_q(tm_q), .prio_id_q(pid_q)
  );

  qtr_id_match #(.ID_W(ID_W)) u_match (
    .id(req_id), .prio_id(pid_q), .hit(id_hit)
  );

  qtr_admit_gate #(.CNT_W(CNT_W)) u_gate (
    .count(be_count), .tidemark(tm_q), .prio_hit(id_hit), .ready(req_ready)
  );

  always_comb begin
    be_inc = req_valid && req_ready && !id_hit;
    be_dec = cmp_valid && cmp_best_effort;
  end

  qtr_be_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(be_inc), .dec(be_dec), .count(be_count)
  );
endmodule

// File: rtl/qtr_checker.sv
module qtr_checker #(
  parameter int ID_W  = 4,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [ID_W-1:0]  req_id,
  input logic             req_ready,
  input logic             cmp_valid,
  input logic             cmp_best_effort,
  input logic [CNT_W-1:0] tm_q,
  input logic [ID_W-1:0]  pid_q,
  input logic [CNT_W-1:0] be_count
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  logic match_c, acc_be, done_be;
  always_comb begin
    match_c = (req_id == pid_q);
    acc_be  = req_valid && req_ready && !match_c;
    done_be = cmp_valid && cmp_best_effort;
  end

  assert_prio_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    match_c |-> req_ready);
  assert_prio_uncounted_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && match_c && !done_be) |=> be_count == $past(be_count));
  assert_block_at_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_q != '0 && be_count >= tm_q && !match_c) |-> !req_ready);
  assert_open_below_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (be_count < tm_q) |-> req_ready);
  assert_count_up_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_be && !done_be && be_count != CMAX) |=> be_count == $past(be_count) + CNT_W'(1));
  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_be && !acc_be && be_count != '0) |=> be_count == $past(be_count) - CNT_W'(1));
  assert_both_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_be && done_be && be_count != '0 && be_count != CMAX) |=> $stable(be_count));
  assert_off_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tm_q == '0) |-> req_ready);
  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (be_count == '0 && !acc_be) |=> be_count == '0);
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (be_count == CMAX && !done_be) |=> be_count == CMAX);
endmodule

bind qos_tidemark_regulator qtr_checker #(.ID_W(ID_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
  .req_ready(req_ready), .cmp_valid(cmp_valid), .cmp_best_effort(cmp_best_effort),
  .tm_q(tm_q), .pid_q(pid_q), .be_count(be_count)
);

// File: tb/qos_tidemark_regulator_test.sv
module qos_tidemark_regulator_test;
  localparam int ID_W  = 4;
  localparam int CNT_W = 6;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, cmp_valid, cmp_best_effort, req_ready;
  logic [ID_W-1:0]  req_id, cfg_prio_id;
  logic [CNT_W-1:0] cfg_tidemark;

  int checks = 0;
  int errors = 0;
  int m_cnt = 0;
  int m_tm = 0;
  int m_pid = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  qos_tidemark_regulator #(.ID_W(ID_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_ready(req_ready), .cmp_valid(cmp_valid), .cmp_best_effort(cmp_best_effort),
    .cfg_tidemark(cfg_tidemark), .cfg_prio_id(cfg_prio_id)
  );

  function automatic bit exp_ready(int id);
    return (id == m_pid) || (m_tm == 0) || (m_cnt < m_tm);
  endfunction

  function automatic string tag_for(int id);
    if (id == m_pid) return "R2";
    if (m_tm == 0)   return "R7";
    if (m_cnt >= m_tm) return "R3";
    return "R4";
  endfunction

  task automatic check(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: req_ready=%0b expected %0b (count=%0d tidemark=%0d)",
               tag, act, exp, m_cnt, m_tm);
    end
  endtask

  // One clock: drive at negedge, check ready, then update model at posedge.
  task automatic step(bit v, int id, bit cv, bit cbe, int tm, int pid, string tag = "");
    bit e;
    bit inc, dec;
    @(negedge clk);
    req_valid = v; req_id = ID_W'(id); cmp_valid = cv; cmp_best_effort = cbe;
    cfg_tidemark = CNT_W'(tm); cfg_prio_id = ID_W'(pid);
    #1;
    e = exp_ready(id);
    check(tag == "" ? tag_for(id) : tag, req_ready, e);
    @(posedge clk);
    inc = v && e && (id != m_pid) && (m_cnt != CMAX);
    dec = cv && cbe && (m_cnt != 0);
    m_cnt = m_cnt + int'(inc) - int'(dec);
    m_tm = tm; m_pid = pid;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int tm, pid;
    void'($urandom(32'd1357));
    rst_n = 1'b0; req_valid = 0; req_id = '0; cmp_valid = 0; cmp_best_effort = 0;
    cfg_tidemark = '0; cfg_prio_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: fresh reset, non-priority request ready
    step(0, 1, 0, 0, 4, 0, "R1");
    step(1, 1, 0, 0, 4, 0, "R1");
    // Example: tidemark 4, master 0 priority, master 1 fills four slots
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 4, 0, "R5");
    step(1, 1, 0, 0, 4, 0, "R3");          // count 4: blocked
    step(1, 0, 0, 0, 4, 0, "R2");          // priority passes, uncounted
    step(1, 2, 0, 0, 4, 0, "R3");
    step(0, 1, 1, 0, 4, 0, "R5");          // completion not best-effort: no change
    step(0, 1, 1, 1, 4, 0, "R3");          // count->3
    step(1, 1, 0, 0, 4, 0, "R4");          // reopened, count->4
    step(1, 1, 1, 1, 4, 0, "R3");          // blocked, completion count->3
    step(1, 3, 1, 1, 4, 0, "R6");          // accept+complete: stays 3
    step(1, 3, 0, 0, 4, 0, "R6");          // count 3 <4 ready -> 4
    step(1, 3, 0, 0, 4, 0, "R3");
    // R8: lower tidemark to 2 with count 4
    step(0, 1, 0, 0, 2, 0, "R3");
    step(0, 1, 1, 1, 2, 0, "R8");          // count->3, still >2
    step(1, 1, 1, 1, 2, 0, "R8");          // count 3 blocked, ->2
    step(1, 1, 1, 1, 2, 0, "R8");          // count 2 blocked, ->1
    step(1, 1, 0, 0, 2, 0, "R8");          // count 1 ready ->2
    // R8: priority ID change applies next cycle
    step(1, 5, 0, 0, 2, 5, "R3");
    step(1, 5, 0, 0, 2, 5, "R2");
    // R9: drain and underflow
    for (int i = 0; i < 4; i++) step(0, 1, 1, 1, 2, 5, "R9");
    step(1, 1, 0, 0, 1, 5, "R9");          // count 0 ready ->1
    step(1, 1, 0, 0, 1, 5, "R3");
    // R7 + saturation
    for (int i = 0; i < CMAX + 5; i++) step(1, 2, 0, 0, 0, 5, "R7");
    step(1, 2, 0, 0, CMAX, 5, "R7");
    step(1, 2, 0, 0, CMAX, 5, "R9");       // count saturated at max -> blocked
    step(0, 2, 1, 1, CMAX, 5, "R9");
    step(1, 2, 0, 0, CMAX, 5, "R9");       // count max-1 -> ready
    for (int i = 0; i < CMAX + 2; i++) step(0, 2, 1, 1, 3, 5, "R9");
    // Constrained random
    tm = 3; pid = 1;
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 40) == 0) tm = $urandom_range(0, 6);
      if ($urandom_range(0, 60) == 0) pid = $urandom_range(0, 3);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 3),
           $urandom_range(0, 2) == 0, $urandom_range(0, 4) != 0, tm, pid);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule